// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timing Generator

This block sits between a flash transaction engine and the pins of a serial flash bus. From a fast reference clock it derives a divided serial clock and a set of active-low chip-select lines. It frames each transaction in a fixed sequence: select low, a programmed number of serial clock cycles, select high, and then a recovery gap. Every interval in that sequence comes from a configuration field counted in reference clocks.

The transaction engine raises a request together with a cycle count. The block answers with a one-cycle ready strobe when it takes the request, and a one-cycle done strobe when the select line rises again. An idle flag tells the engine whether the block is quiet. The configuration covers the clock divisor, the selected device, a decode flag and four delays. It is captured only while the enable is low, so retiming can never disturb a transaction that is in flight. The engine is expected to launch data on falling serial clock edges and to sample on rising ones.

Top module: `spi_csclk_gen`

## Requirements
- R1: After reset, `cs_n` is 4'b1111, `sclk` is low, `idle` is high, and `xfer_ready` and `xfer_done` are low.
- R2: Inside a frame the serial clock idles low. Each high phase and each low phase between rising edges lasts `cfg_div`+1 reference clocks. Exactly `xfer_len`+1 rising edges occur. The select stays low for L + 2·(`xfer_len`+1)·(`cfg_div`+1) + T reference clocks.
- R3: With `cfg_decode` low, the select pattern during a frame has only bit `cfg_cs[1:0]` low (device 0 gives 4'b1110, device 3 gives 4'b0111).
- R4: With `cfg_decode` high, the select pattern during a frame is `cfg_cs` driven unchanged.
- R5: The first rising serial clock edge is seen L+`cfg_div`+1 reference clocks after the select falls, where L = `cfg_lead`, or 1 when `cfg_lead` is 0.
- R6: The select rises T reference clocks after the last falling serial clock edge, where T = `cfg_trail`, or 1 when it is 0. `xfer_done` is high for exactly the first cycle in which the select is high again.
- R7: After `xfer_done`, `idle` stays low and the select stays high for max(`cfg_gap`, 2·(`cfg_div`+1)) reference clocks.
- R8: When the select pattern differs from that of the previous accepted transaction, the select stays high for S cycles, counted from the `xfer_ready` cycle, where S = `cfg_switch`, or 1 when it is 0. For the same device, or for the first transaction after reset, the select falls in the `xfer_ready` cycle itself.
- R9: A request is taken only while `idle` is high and `cfg_enable` is high. It is answered by a single-cycle `xfer_ready` in the following cycle.
- R10: Configuration inputs are captured only while `cfg_enable` is low. Changes made while it is high have no effect on any frame.
- R11: When `cfg_enable` is low at a clock edge, the next cycle shows the select high, `sclk` low and `idle` high, and the aborted frame produces no `xfer_done`.
- R12: `idle` is low for the whole time a select line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_enable | input | 1 | Global enable; configuration is captured while low |
| cfg_div | input | 4 | Serial clock divisor; period is 2·(div+1) reference clocks |
| cfg_cs | input | 4 | Device number, or raw select value in decode mode |
| cfg_decode | input | 1 | 1: drive `cfg_cs` raw for an external decoder |
| cfg_lead | input | 8 | Select-low to first clock delay |
| cfg_trail | input | 8 | Last clock to select-high delay |
| cfg_gap | input | 8 | Minimum select-high time between frames |
| cfg_switch | input | 8 | Extra select-high gap when the device changes |
| xfer_req | input | 1 | Transaction request from the engine |
| xfer_len | input | 8 | Serial clock cycles in the frame, minus one |
| xfer_ready | output | 1 | One-cycle strobe: request taken |
| xfer_done | output | 1 | One-cycle strobe: select released |
| idle | output | 1 | High when no transaction is in progress |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low chip-select lines |

## Verification
`xfer_ready` rises in the cycle after the edge that sees the request. Every other result is counted from that cycle: the select falls 0 or S cycles later, the first serial rising edge follows after L+div+1 further cycles, and `xfer_done` appears in the first select-high cycle. `idle` returns exactly max(gap, period) cycles after `xfer_done`. The bench samples on the falling reference edge and counts cycles from each of these landmarks, so every interval is compared as an exact cycle count rather than a window. It sweeps divisor, lead, trail, gap and length combinations, and walks device numbers and raw decode values, so that the switch gap and the select patterns are covered.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;

  // Frame sequencing phases
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SWITCH = 3'd1,
    ST_LEAD   = 3'd2,
    ST_CLOCK  = 3'd3,
    ST_TRAIL  = 3'd4,
    ST_GAP    = 3'd5
  } tg_state_e;

endpackage

// File: rtl/spi_tg_cfg.sv
// Configuration shadow: follows the inputs while disabled, frozen while enabled.
module spi_tg_cfg #(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int CS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_in,
  input  logic [CS_W-1:0]  cs_in,
  input  logic             dec_in,
  input  logic [DLY_W-1:0] lead_in,
  input  logic [DLY_W-1:0] trail_in,
  input  logic [DLY_W-1:0] gap_in,
  input  logic [DLY_W-1:0] sw_in,
  output logic [DIV_W-1:0] div_q,
  output logic             dec_q,
  output logic [DLY_W-1:0] lead_q,
  output logic [DLY_W-1:0] trail_q,
  output logic [DLY_W-1:0] gap_q,
  output logic [DLY_W-1:0] sw_q,
  output logic [CS_W-1:0]  pat
);

  localparam int IDX_W = $clog2(CS_W);

  logic [CS_W-1:0] cs_q;
  logic            load;

  assign load = !enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      cs_q    <= '0;
      dec_q   <= 1'b0;
      lead_q  <= '0;
      trail_q <= '0;
      gap_q   <= '0;
      sw_q    <= '0;
    end else if (load) begin
      div_q   <= div_in;
      cs_q    <= cs_in;
      dec_q   <= dec_in;
      lead_q  <= lead_in;
      trail_q <= trail_in;
      gap_q   <= gap_in;
      sw_q    <= sw_in;
    end
  end

  // Select pattern: raw value for an external decoder, or one line low
  for (genvar i = 0; i < CS_W; i++) begin : g_line
    assign pat[i] = dec_q ? cs_q[i] : (cs_q[IDX_W-1:0] != IDX_W'(i));
  end

endmodule

// File: rtl/spi_tg_sclk.sv
// Serial clock divider: half period of div+1 reference clocks, 2*(len+1) edges.
module spi_tg_sclk #(
  parameter int DIV_W = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic [LEN_W-1:0] len,
  output logic             sclk,
  output logic             last_edge
);

  logic [LEN_W-1:0] len_q, len_d;
  logic [DIV_W-1:0] half_q, half_d;
  logic [LEN_W:0]   edge_q, edge_d;
  logic             sclk_q, sclk_d;
  logic             half_end;

  assign half_end  = (half_q == '0);
  assign last_edge = run && half_end && (edge_q == '0);
  assign sclk      = sclk_q;

  always_comb begin
    len_d  = accept ? len : len_q;
    half_d = half_q;
    edge_d = edge_q;
    sclk_d = sclk_q;
    if (!run) begin
      half_d = div;
      edge_d = {len_q, 1'b1};
      sclk_d = 1'b0;
    end else if (half_end) begin
      half_d = div;
      edge_d = edge_q - 1'b1;
      sclk_d = !sclk_q;
    end else begin
      half_d = half_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      half_q <= '0;
      edge_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      len_q  <= len_d;
      half_q <= half_d;
      edge_q <= edge_d;
      sclk_q <= sclk_d;
    end
  end

endmodule

// File: rtl/spi_tg_seq.sv
// Frame sequencer: switch gap, lead, clocking, trail and recovery gap.
module spi_tg_seq
  import spi_tg_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int CS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             req,
  input  logic [DIV_W-1:0] div,
  input  logic [DLY_W-1:0] lead,
  input  logic [DLY_W-1:0] trail,
  input  logic [DLY_W-1:0] gap,
  input  logic [DLY_W-1:0] sw,
  input  logic [CS_W-1:0]  pat,
  input  logic             last_edge,
  output logic             accept,
  output logic             run,
  output logic             cs_active,
  output logic             idle,
  output logic             ready,
  output logic             done
);

  tg_state_e        state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [CS_W-1:0]  lastpat_q, lastpat_d;
  logic             lastv_q, lastv_d;
  logic             ready_d, done_d;
  logic [DLY_W-1:0] lead_m1, trail_m1, sw_m1, gap_m1, per_m1;
  logic             cnt_zero;

  // Zero-length delays still take one cycle; gap is at least one clock period
  always_comb begin
    per_m1   = DLY_W'({div, 1'b1});
    lead_m1  = (lead  == '0) ? '0 : lead  - 1'b1;
    trail_m1 = (trail == '0) ? '0 : trail - 1'b1;
    sw_m1    = (sw    == '0) ? '0 : sw    - 1'b1;
    gap_m1   = ((gap != '0) && ((gap - 1'b1) > per_m1)) ? gap - 1'b1 : per_m1;
  end

  assign cnt_zero  = (cnt_q == '0);
  assign accept    = enable && req && (state_q == ST_IDLE);
  assign run       = enable && (state_q == ST_CLOCK);
  assign cs_active = (state_q == ST_LEAD) || (state_q == ST_CLOCK) ||
                     (state_q == ST_TRAIL);
  assign idle      = (state_q == ST_IDLE);
  assign ready     = ready_q;
  assign done      = done_q;

  logic ready_q, done_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_zero ? cnt_q : cnt_q - 1'b1;
    lastpat_d = accept ? pat : lastpat_q;
    lastv_d   = lastv_q || accept;
    ready_d   = accept;
    done_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (lastv_q && (pat != lastpat_q)) begin
            state_d = ST_SWITCH;
            cnt_d   = sw_m1;
          end else begin
            state_d = ST_LEAD;
            cnt_d   = lead_m1;
          end
        end
      end
      ST_SWITCH: if (cnt_zero) begin
        state_d = ST_LEAD;
        cnt_d   = lead_m1;
      end
      ST_LEAD: if (cnt_zero) state_d = ST_CLOCK;
      ST_CLOCK: if (last_edge) begin
        state_d = ST_TRAIL;
        cnt_d   = trail_m1;
      end
      ST_TRAIL: if (cnt_zero) begin
        state_d = ST_GAP;
        cnt_d   = gap_m1;
        done_d  = 1'b1;
      end
      ST_GAP: if (cnt_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (!enable) begin
      state_d = ST_IDLE;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      lastpat_q <= '0;
      lastv_q   <= 1'b0;
      ready_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      lastpat_q <= lastpat_d;
      lastv_q   <= lastv_d;
      ready_q   <= ready_d;
      done_q    <= done_d;
    end
  end

endmodule

// File: rtl/spi_csclk_gen.sv
// Serial flash clock and chip-select timing generator (top).
module spi_csclk_gen #(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int LEN_W = 8,
  parameter int CS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [CS_W-1:0]  cfg_cs,
  input  logic             cfg_decode,
  input  logic [DLY_W-1:0] cfg_lead,
  input  logic [DLY_W-1:0] cfg_trail,
  input  logic [DLY_W-1:0] cfg_gap,
  input  logic [DLY_W-1:0] cfg_switch,
  input  logic             xfer_req,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             xfer_ready,
  output logic             xfer_done,
  output logic             idle,
  output logic             sclk,
  output logic [CS_W-1:0]  cs_n
);

  logic             rst_meta, rst_s;
  logic [DIV_W-1:0] div_q;
  logic             dec_q;
  logic [DLY_W-1:0] lead_q, trail_q, gap_q, sw_q;
  logic [CS_W-1:0]  pat;
  logic             accept, run, cs_active, last_edge;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  spi_tg_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CS_W(CS_W)) u_cfg (
    .clk(clk), .rst_n(rst_s), .enable(cfg_enable),
    .div_in(cfg_div), .cs_in(cfg_cs), .dec_in(cfg_decode),
    .lead_in(cfg_lead), .trail_in(cfg_trail), .gap_in(cfg_gap), .sw_in(cfg_switch),
    .div_q(div_q), .dec_q(dec_q), .lead_q(lead_q), .trail_q(trail_q),
    .gap_q(gap_q), .sw_q(sw_q), .pat(pat)
  );

  spi_tg_seq #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CS_W(CS_W)) u_seq (
    .clk(clk), .rst_n(rst_s), .enable(cfg_enable), .req(xfer_req),
    .div(div_q), .lead(lead_q), .trail(trail_q), .gap(gap_q), .sw(sw_q),
    .pat(pat), .last_edge(last_edge), .accept(accept), .run(run),
    .cs_active(cs_active), .idle(idle), .ready(xfer_ready), .done(xfer_done)
  );

  spi_tg_sclk #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_sclk (
    .clk(clk), .rst_n(rst_s), .accept(accept), .run(run),
    .div(div_q), .len(xfer_len), .sclk(sclk), .last_edge(last_edge)
  );

  assign cs_n = cs_active ? pat : '1;

endmodule

// File: rtl/spi_csclk_gen_chk.sv
module spi_csclk_gen_chk #(
  parameter int CS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic [CS_W-1:0] cs_n,
  input logic            sclk,
  input logic            idle,
  input logic            ready,
  input logic            done,
  input logic            dec
);

  localparam logic [CS_W-1:0] ALL_HI = '1;

  // R2
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (cs_n != ALL_HI));

  // R3
  onehot_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec && (cs_n != ALL_HI)) |-> $onehot(~cs_n));

  // R6
  done_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((cs_n == ALL_HI) && ($past(cs_n) != ALL_HI)));

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R11
  disable_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((cs_n == ALL_HI) && !sclk && idle));

  // R12
  idle_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != ALL_HI) |-> !idle);

endmodule

bind spi_csclk_gen spi_csclk_gen_chk #(.CS_W(CS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .cs_n(cs_n), .sclk(sclk),
  .idle(idle), .ready(xfer_ready), .done(xfer_done), .dec(dec_q)
);

// File: tb/spi_csclk_gen_test.sv
`timescale 1ns/1ps
module spi_csclk_gen_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_enable, cfg_decode, xfer_req;
  logic [3:0] cfg_div, cfg_cs;
  logic [7:0] cfg_lead, cfg_trail, cfg_gap, cfg_switch, xfer_len;
  logic       xfer_ready, xfer_done, idle, sclk;
  logic [3:0] cs_n;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // Bench copy of the programmed configuration
  int       c_div, c_lead, c_trail, c_gap, c_sw;
  bit [3:0] c_cs;
  bit       c_dec;
  bit [3:0] prev_pat;
  bit       prev_v = 1'b0;

  always #2.5 clk = ~clk;

  spi_csclk_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_div(cfg_div),
    .cfg_cs(cfg_cs), .cfg_decode(cfg_decode), .cfg_lead(cfg_lead),
    .cfg_trail(cfg_trail), .cfg_gap(cfg_gap), .cfg_switch(cfg_switch),
    .xfer_req(xfer_req), .xfer_len(xfer_len), .xfer_ready(xfer_ready),
    .xfer_done(xfer_done), .idle(idle), .sclk(sclk), .cs_n(cs_n)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk_eq(input string rq, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic bit [3:0] pat_of();
    return c_dec ? c_cs : (4'hF & ~(4'h1 << c_cs[1:0]));
  endfunction

  task automatic configure(input int dv, input bit [3:0] cs, input bit dec,
                           input int ld, input int tr, input int gp, input int sw);
    @(negedge clk);
    cfg_enable = 1'b0;
    cfg_div = 4'(dv); cfg_cs = cs; cfg_decode = dec;
    cfg_lead = 8'(ld); cfg_trail = 8'(tr); cfg_gap = 8'(gp); cfg_switch = 8'(sw);
    c_div = dv; c_cs = cs; c_dec = dec; c_lead = ld; c_trail = tr; c_gap = gp; c_sw = sw;
    @(negedge clk);
    @(negedge clk);
    cfg_enable = 1'b1;
    @(negedge clk);
  endtask

  // One frame, every interval counted on falling-edge samples
  task automatic run_xfer(input int len);
    int L, T, P, G, S, N, w, rc, low, first_hi, last_hi, rises, run, g;
    bit [3:0] ep;
    bit sw_exp, prv, bad_pat, bad_idle, bad_half, bad_gap;
    L = (c_lead == 0) ? 1 : c_lead;
    T = (c_trail == 0) ? 1 : c_trail;
    S = (c_sw == 0) ? 1 : c_sw;
    P = 2 * (c_div + 1);
    G = (c_gap > P) ? c_gap : P;
    N = len + 1;
    ep = pat_of();
    sw_exp = prev_v && (ep != prev_pat);
    xfer_len = 8'(len);
    xfer_req = 1'b1;
    w = 0;
    do begin @(negedge clk); w++; end while (!xfer_ready && w < 1000);
    chk_eq("R9 ready cycle", w, 1);
    xfer_req = 1'b0;
    rc = 0;
    while (cs_n == 4'hF && rc < 1000) begin @(negedge clk); rc++; end
    chk_eq("R8 select delay after ready", rc, sw_exp ? S : 0);
    low = 0; first_hi = -1; last_hi = -1; rises = 0; run = 0; prv = 1'b0;
    bad_pat = 1'b0; bad_idle = 1'b0; bad_half = 1'b0;
    while (cs_n != 4'hF && low < 5000) begin
      if (cs_n != ep) bad_pat = 1'b1;
      if (idle) bad_idle = 1'b1;
      if (sclk && !prv) begin
        rises++;
        if (first_hi < 0) first_hi = low;
        else if (run != c_div + 1) bad_half = 1'b1;
        run = 1;
      end else if (!sclk && prv) begin
        if (run != c_div + 1) bad_half = 1'b1;
        run = 1;
      end else run++;
      if (sclk) last_hi = low;
      prv = sclk;
      low++;
      @(negedge clk);
    end
    chk_eq(c_dec ? "R4 raw select pattern" : "R3 one-hot select pattern", bad_pat, 0);
    chk_eq("R12 idle low in frame", bad_idle, 0);
    chk_eq("R2 half period length", bad_half, 0);
    chk_eq("R2 rising edge count", rises, N);
    chk_eq("R2 frame length", low, L + 2 * N * (c_div + 1) + T);
    chk_eq("R5 lead to first rise", first_hi, L + c_div + 1);
    chk_eq("R6 trail after last fall", low - 1 - last_hi, T);
    chk_eq("R6 done at release", xfer_done, 1);
    g = 0; bad_gap = 1'b0;
    while (!idle && g < 1000) begin
      @(negedge clk);
      g++;
      if (cs_n != 4'hF || (g == 1 && xfer_done)) bad_gap = 1'b1;
    end
    chk_eq("R7 recovery gap", g, G);
    chk_eq("R7 select high in gap", bad_gap, 0);
    prev_pat = ep;
    prev_v = 1'b1;
  endtask

  initial begin
    int divs[3];
    int leads[3];
    int trails[2];
    int gaps[3];
    bit [3:0] raws[4];
    bit seen;
    divs = '{0, 1, 3}; leads = '{0, 1, 5}; trails = '{0, 2}; gaps = '{0, 3, 20};
    raws = '{4'h5, 4'hA, 4'h0, 4'hC};
    rst_n = 1'b0; cfg_enable = 1'b0; xfer_req = 1'b0; xfer_len = 8'd0;
    cfg_div = 4'd0; cfg_cs = 4'd0; cfg_decode = 1'b0;
    cfg_lead = 8'd0; cfg_trail = 8'd0; cfg_gap = 8'd0; cfg_switch = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_eq("R1 cs_n after reset", cs_n, 4'hF);
    chk_eq("R1 sclk after reset", sclk, 0);
    chk_eq("R1 idle after reset", idle, 1);
    chk_eq("R1 ready after reset", xfer_ready, 0);
    chk_eq("R1 done after reset", xfer_done, 0);

    // R9 request while disabled is ignored
    xfer_req = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (xfer_ready || cs_n != 4'hF) seen = 1'b1;
    end
    xfer_req = 1'b0;
    chk_eq("R9 no accept while disabled", seen, 0);

    // Timing sweep on device 0
    foreach (divs[a]) foreach (leads[b]) foreach (trails[c]) foreach (gaps[d])
      for (int n = 0; n < 3; n += 2) begin
        configure(divs[a], 4'd0, 1'b0, leads[b], trails[c], gaps[d], 7);
        run_xfer(n);
      end

    // Same device again: no switch gap (R8)
    run_xfer(1);

    // Walk one-hot devices with a switch gap (R3, R8)
    for (int k = 1; k < 4; k++) begin
      configure(1, 4'(k), 1'b0, 2, 1, 0, 3);
      run_xfer(1);
    end

    // Raw decode values (R4, R8 with zero switch setting)
    foreach (raws[r]) begin
      configure(0, raws[r], 1'b1, 1, 1, 2, (r == 1) ? 0 : 4);
      run_xfer(0);
    end

    // R10 changes while enabled do not take effect
    configure(1, 4'd1, 1'b0, 2, 2, 4, 2);
    run_xfer(0);
    cfg_div = 4'd3; cfg_lead = 8'd9; cfg_cs = 4'd2; cfg_decode = 1'b1; cfg_gap = 8'd30;
    run_xfer(2);

    // R11 abort by dropping enable mid-frame
    configure(3, 4'd1, 1'b0, 1, 1, 1, 1);
    xfer_len = 8'd5;
    xfer_req = 1'b1;
    do @(negedge clk); while (!xfer_ready);
    xfer_req = 1'b0;
    do @(negedge clk); while (!sclk);
    cfg_enable = 1'b0;
    @(negedge clk);
    chk_eq("R11 select released on disable", cs_n, 4'hF);
    chk_eq("R11 sclk parked low", sclk, 0);
    chk_eq("R11 idle after abort", idle, 1);
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (xfer_done || cs_n != 4'hF) seen = 1'b1;
      @(negedge clk);
    end
    chk_eq("R11 no done after abort", seen, 0);

    summary();
    $finish;
  end

endmodule